// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is the data-register side of a debug port. A test access port controller, which lives elsewhere, hands it capture, shift and update strobes together with the serial input. Each scan moves a 38-bit word through the chain, least significant bit first. The word holds a 32-bit data field, a 5-bit register number and a direction bit. When the update strobe arrives with the direction bit set, the named register is written. With the direction bit clear, the update only records the register number. The register recorded this way is loaded into the data field at the capture of the next scan. Reads are therefore pipelined by one scan.

Behind the chain sits a small debug register file. It holds a debug control register, whose bit 4 selects monitor-mode debug and whose width follows the module version. It also holds a debug status word driven by the core, a vector catch register and a parameterised number of watch units. The watch units are storage only. The block also carries a two-way message channel between the debugger and the core. The channel has one data register and a read-only control register that holds two handshake flags and the module version. Capturing the channel data register pops the word the core posted. For that reason a debugger ends a read burst with a scan that points at the control register, which can be read freely.

The whole block runs on one clock. The core-side strobes are expected to be synchronous to that clock already.

Top module: `dbgscan_chain`

## Requirements
- R1: The chain is 38 bits long. On each shift cycle `tdi` enters bit 37 and every bit moves one place toward bit 0. `tdo` always shows bit 0, so a word leaves least significant bit first.
- R2: An update whose bit 37 is 1 writes bits 31:0 into the register numbered by bits 36:32.
- R3: An update whose bit 37 is 0 changes no register and only records bits 36:32 as the read address. The next capture loads that register into bits 31:0 and clears bits 37:32.
- R4: Address 4, the channel control register, reads the flag `rx_full` in bit 0, the flag `tx_full` in bit 1 and the VERSION parameter in bits 31:28. All its other bits read 0. Capturing it has no side effects, and writes to it are ignored.
- R5: A debugger write to address 5 while `rx_full` is 0 stores the word on `core_rd_data` and sets `rx_full`. A `core_rd` pulse clears `rx_full`.
- R6: A debugger write to address 5 while `rx_full` is 1 is dropped, and `core_rd_data` keeps its word.
- R7: A `core_wr` pulse while `tx_full` is 0 stores `core_wr_data` and sets `tx_full`. A capture of address 5 returns that word and clears `tx_full`, so two such captures pop two words.
- R8: A `core_wr` pulse while `tx_full` is 1 is dropped, and the stored word is kept.
- R9: Address 0, debug control, keeps the low CTL_W bits of a write (CTL_W is 6 for version 6) and reads the other bits as 0. `monitor_en` equals bit 4 of this register. Address 1 reads `dbg_stat_in`, zero-extended.
- R10: Address 2, vector catch, keeps the low 8 bits of a write. Those bits also drive `vec_catch`.
- R11: Watch unit i sits at base address 8*(i+1). Offsets 0 to 3 there are 32-bit registers, offset 4 keeps 9 bits and offset 5 keeps 8 bits. Bits above a register's width read 0.
- R12: Addresses 3, 6, 7, 14, 15 and 22 to 31 read 0 with the default two watch units. Writes to them change nothing.
- R13: Reset clears every register, both flags, the chain and the read address. The read address resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture strobe: load the addressed register into the chain |
| shift_en | input | 1 | Shift strobe: move the chain one bit |
| upd_en | input | 1 | Update strobe: write, or record the read address |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| dbg_stat_in | input | STS_W | Debug status supplied by the core |
| monitor_en | output | 1 | Monitor-mode enable from debug control bit 4 |
| vec_catch | output | VCATCH_W | Vector catch enables |
| core_rd | input | 1 | Core takes the word sent by the debugger |
| core_rd_data | output | 32 | Word sent by the debugger |
| rx_full | output | 1 | Debugger-to-core word pending |
| core_wr | input | 1 | Core posts a word for the debugger |
| core_wr_data | input | 32 | Word posted by the core |
| tx_full | output | 1 | Core-to-debugger word pending |

## Verification
On every cycle, the assertions check a few properties. The serial input must land in the top chain bit, and a capture must leave the address and direction bits at zero. Neither channel word may change while its full flag is set, a consuming capture must clear the transmit flag, and the receive flag may rise only after a debugger write to the data address. The bench's scenarios are the only place to show the one-scan read latency. They also show the masked widths of each register, the silence of unused addresses, the dropped writes seen from the other side of the channel, and the popping of two posted words by two back-to-back captures.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;

   localparam int unsigned DATA_W     = 32;
   localparam int unsigned ADDR_W     = 5;
   localparam int unsigned CHAIN_W    = DATA_W + ADDR_W + 1;
   localparam int unsigned DIR_BIT    = CHAIN_W - 1;
   localparam int unsigned WATCH_SPAN = 8;
   localparam int unsigned WATCH_REGS = 6;
   localparam int unsigned MON_BIT    = 4;
   localparam int unsigned RX_BIT     = 0;
   localparam int unsigned TX_BIT     = 1;
   localparam int unsigned VER_LSB    = 28;

   localparam logic [ADDR_W-1:0] A_DBGCTL = 5'd0;
   localparam logic [ADDR_W-1:0] A_DBGSTS = 5'd1;
   localparam logic [ADDR_W-1:0] A_VCATCH = 5'd2;
   localparam logic [ADDR_W-1:0] A_CHCTL  = 5'd4;
   localparam logic [ADDR_W-1:0] A_CHDAT  = 5'd5;

   // debug control width per module version
   function automatic int unsigned ctl_width(input int unsigned ver);
      case (ver)
         1:       return 3;
         2:       return 4;
         default: return 6;
      endcase
   endfunction

   // debug status width per module version
   function automatic int unsigned sts_width(input int unsigned ver);
      return (ver == 6) ? 10 : 5;
   endfunction

   // width of watch-unit register at offset k
   function automatic int unsigned watch_width(input int unsigned k);
      case (k)
         4:       return 9;
         5:       return 8;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/dbgscan_shifter.sv
module dbgscan_shifter #(
   parameter int unsigned CHAIN_W = 38,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic               shift_en,
   input  logic               upd_en,
   input  logic               tdi,
   input  logic [DATA_W-1:0]  cap_word,
   output logic               tdo,
   output logic [CHAIN_W-1:0] chain,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic               upd_wr,
   output logic               cap_fire
);

   if (CHAIN_W != DATA_W + ADDR_W + 1) begin : g_bad_chain
      $error("dbgscan_shifter: chain length must be data + address + 1");
   end

   logic               shift_fire;
   logic               upd_fire;
   logic [CHAIN_W-1:0] chain_q;
   logic [ADDR_W-1:0]  rd_addr_q;

   assign cap_fire   = cap_en;
   assign shift_fire = shift_en & ~cap_en;
   assign upd_fire   = upd_en & ~cap_en & ~shift_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q   <= '0;
         rd_addr_q <= '0;
      end else if (cap_fire) begin
         chain_q <= CHAIN_W'(cap_word);
      end else if (shift_fire) begin
         chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
      end else if (upd_fire && !chain_q[CHAIN_W-1]) begin
         rd_addr_q <= chain_q[DATA_W +: ADDR_W];
      end
   end

   assign upd_wr  = upd_fire & chain_q[CHAIN_W-1];
   assign tdo     = chain_q[0];
   assign chain   = chain_q;
   assign rd_addr = rd_addr_q;

endmodule

// File: rtl/dbgscan_chan.sv
module dbgscan_chan #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_wr,
   input  logic [DATA_W-1:0] dbg_wdata,
   input  logic              consume,
   input  logic              core_rd,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic              rx_full,
   output logic              tx_full,
   output logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] tx_data
);

   logic              rx_q, tx_q;
   logic [DATA_W-1:0] rx_word_q, tx_word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q      <= 1'b0;
         tx_q      <= 1'b0;
         rx_word_q <= '0;
         tx_word_q <= '0;
      end else begin
         if (core_rd) rx_q <= 1'b0;
         if (dbg_wr && !rx_q) begin
            rx_q      <= 1'b1;
            rx_word_q <= dbg_wdata;
         end
         if (consume) tx_q <= 1'b0;
         if (core_wr && !tx_q) begin
            tx_q      <= 1'b1;
            tx_word_q <= core_wdata;
         end
      end
   end

   assign rx_full = rx_q;
   assign tx_full = tx_q;
   assign rx_data = rx_word_q;
   assign tx_data = tx_word_q;

endmodule

// File: rtl/dbgscan_watch.sv
module dbgscan_watch
   import dbgscan_pkg::*;
#(
   parameter logic [ADDR_W-1:0] BASE = 5'd8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot_val [WATCH_REGS];

   for (genvar k = 0; k < WATCH_REGS; k++) begin : g_slot
      localparam int unsigned W = watch_width(k);
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && wr_addr == BASE + ADDR_W'(k)) begin
            q <= wr_data[W-1:0];
         end
      end
      assign slot_val[k] = DATA_W'(q);
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < WATCH_REGS; k++) begin
         if (rd_addr == BASE + ADDR_W'(k)) rd_data = slot_val[k];
      end
   end

endmodule

// File: rtl/dbgscan_chain.sv
module dbgscan_chain
   import dbgscan_pkg::*;
#(
   parameter int unsigned VERSION   = 6,
   parameter int unsigned NUM_WATCH = 2,
   parameter int unsigned VCATCH_W  = 8,
   parameter int unsigned CTL_W     = ctl_width(VERSION),
   parameter int unsigned STS_W     = sts_width(VERSION)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic                shift_en,
   input  logic                upd_en,
   input  logic                tdi,
   output logic                tdo,
   input  logic [STS_W-1:0]    dbg_stat_in,
   output logic                monitor_en,
   output logic [VCATCH_W-1:0] vec_catch,
   input  logic                core_rd,
   output logic [DATA_W-1:0]   core_rd_data,
   output logic                rx_full,
   input  logic                core_wr,
   input  logic [DATA_W-1:0]   core_wr_data,
   output logic                tx_full
);

   if (VERSION > 15) begin : g_bad_ver
      $error("dbgscan_chain: VERSION must fit in 4 bits");
   end
   if (NUM_WATCH < 1 || NUM_WATCH > 3) begin : g_bad_watch
      $error("dbgscan_chain: NUM_WATCH must be 1 to 3");
   end
   if (CTL_W < 1 || CTL_W > DATA_W || STS_W > DATA_W || VCATCH_W > DATA_W) begin : g_bad_w
      $error("dbgscan_chain: register width out of range");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic [ADDR_W-1:0]  rd_addr_q;
   logic               upd_wr;
   logic               cap_fire;
   logic [DATA_W-1:0]  cap_word;
   logic [ADDR_W-1:0]  wr_addr;
   logic [DATA_W-1:0]  wr_data;
   logic               consume;
   logic [DATA_W-1:0]  tx_word;
   logic [CTL_W-1:0]   ctl_q;
   logic [VCATCH_W-1:0] vc_q;
   logic [DATA_W-1:0]  watch_rd [NUM_WATCH];
   logic [DATA_W-1:0]  watch_any;
   logic [DATA_W-1:0]  chctl_val;

   dbgscan_shifter #(
      .CHAIN_W (CHAIN_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .tdi      (tdi),
      .cap_word (cap_word),
      .tdo      (tdo),
      .chain    (chain_q),
      .rd_addr  (rd_addr_q),
      .upd_wr   (upd_wr),
      .cap_fire (cap_fire)
   );

   assign wr_addr = chain_q[DATA_W +: ADDR_W];
   assign wr_data = chain_q[DATA_W-1:0];
   assign consume = cap_fire && (rd_addr_q == A_CHDAT);

   dbgscan_chan #(
      .DATA_W (DATA_W)
   ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_wr     (upd_wr && wr_addr == A_CHDAT),
      .dbg_wdata  (wr_data),
      .consume    (consume),
      .core_rd    (core_rd),
      .core_wr    (core_wr),
      .core_wdata (core_wr_data),
      .rx_full    (rx_full),
      .tx_full    (tx_full),
      .rx_data    (core_rd_data),
      .tx_data    (tx_word)
   );

   for (genvar i = 0; i < NUM_WATCH; i++) begin : g_watch
      dbgscan_watch #(
         .BASE (ADDR_W'((i + 1) * WATCH_SPAN))
      ) u_watch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (upd_wr),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_addr (rd_addr_q),
         .rd_data (watch_rd[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         vc_q  <= '0;
      end else if (upd_wr) begin
         if (wr_addr == A_DBGCTL) ctl_q <= wr_data[CTL_W-1:0];
         if (wr_addr == A_VCATCH) vc_q  <= wr_data[VCATCH_W-1:0];
      end
   end

   if (CTL_W > MON_BIT) begin : g_mon
      assign monitor_en = ctl_q[MON_BIT];
   end else begin : g_no_mon
      assign monitor_en = 1'b0;
   end

   assign vec_catch = vc_q;

   always_comb begin
      chctl_val               = '0;
      chctl_val[VER_LSB +: 4] = 4'(VERSION);
      chctl_val[RX_BIT]       = rx_full;
      chctl_val[TX_BIT]       = tx_full;
   end

   always_comb begin
      watch_any = '0;
      for (int i = 0; i < NUM_WATCH; i++) watch_any = watch_any | watch_rd[i];
   end

   always_comb begin
      case (rd_addr_q)
         A_DBGCTL: cap_word = DATA_W'(ctl_q);
         A_DBGSTS: cap_word = DATA_W'(dbg_stat_in);
         A_VCATCH: cap_word = DATA_W'(vc_q);
         A_CHCTL:  cap_word = chctl_val;
         A_CHDAT:  cap_word = tx_word;
         default:  cap_word = watch_any;
      endcase
   end

endmodule

// File: rtl/dbgscan_chain_chk.sv
module dbgscan_chain_chk
   import dbgscan_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               cap_en,
   input logic               shift_en,
   input logic               upd_en,
   input logic               tdi,
   input logic               rx_full,
   input logic               tx_full,
   input logic [DATA_W-1:0]  core_rd_data,
   input logic [CHAIN_W-1:0] chain,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [DATA_W-1:0]  tx_word
);

   assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> chain[DIR_BIT] == $past(tdi));

   assert_cap_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> chain[DIR_BIT:DATA_W] == '0);

   assert_rx_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(upd_en && !cap_en && !shift_en && chain[DIR_BIT]
                               && chain[DATA_W +: ADDR_W] == A_CHDAT));

   assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |=> $stable(core_rd_data));

   assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && rd_addr == A_CHDAT && tx_full) |=> !tx_full);

   assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |=> $stable(tx_word));

endmodule

bind dbgscan_chain dbgscan_chain_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cap_en       (cap_en),
   .shift_en     (shift_en),
   .upd_en       (upd_en),
   .tdi          (tdi),
   .rx_full      (rx_full),
   .tx_full      (tx_full),
   .core_rd_data (core_rd_data),
   .chain        (chain_q),
   .rd_addr      (rd_addr_q),
   .tx_word      (tx_word)
);

// File: tb/dbgscan_chain_bench.sv
`timescale 1ns/1ps
module dbgscan_chain_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
   logic        core_rd = 1'b0, core_wr = 1'b0;
   logic [31:0] core_wr_data = '0;
   logic [9:0]  stat_in = '0;
   wire         tdo, rx_full, tx_full, monitor_en;
   wire [31:0]  core_rd_data;
   wire [7:0]   vec_catch;

   always #4 clk = ~clk;

   dbgscan_chain u_dbgscan_chain (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
      .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .dbg_stat_in(stat_in),
      .monitor_en(monitor_en), .vec_catch(vec_catch), .core_rd(core_rd),
      .core_rd_data(core_rd_data), .rx_full(rx_full), .core_wr(core_wr),
      .core_wr_data(core_wr_data), .tx_full(tx_full)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   logic [37:0] m_sr;
   logic [4:0]  m_ra;
   logic [31:0] m_reg [32];
   bit          m_rx, m_tx;
   logic [31:0] m_din, m_dout;

   function automatic logic [31:0] m_mask(input logic [4:0] a);
      case (a)
         5'd0:                return 32'h3F;
         5'd2:                return 32'hFF;
         5'd12, 5'd20:        return 32'h1FF;
         5'd13, 5'd21:        return 32'hFF;
         5'd8, 5'd9, 5'd10, 5'd11,
         5'd16, 5'd17, 5'd18, 5'd19: return 32'hFFFF_FFFF;
         default:             return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [4:0] a);
      case (a)
         5'd1:    return {22'b0, stat_in};
         5'd4:    return {4'd6, 26'b0, m_tx, m_rx};
         5'd5:    return m_dout;
         default: return m_reg[a];
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit nrx, ntx;
      logic [31:0] v;
      logic [4:0] a;
      if (!rst_n) begin
         m_sr = '0; m_ra = '0; m_rx = 0; m_tx = 0; m_din = '0; m_dout = '0;
         for (int i = 0; i < 32; i++) m_reg[i] = '0;
      end else begin
         nrx = m_rx; ntx = m_tx;
         if (core_rd) nrx = 0;
         if (cap_en) begin
            v = m_read(m_ra);
            if (m_ra == 5'd5) ntx = 0;
            m_sr = {6'b0, v};
         end else if (shift_en) begin
            m_sr = {tdi, m_sr[37:1]};
         end else if (upd_en) begin
            a = m_sr[36:32];
            if (m_sr[37]) begin
               if (a == 5'd5) begin
                  if (!m_rx) begin m_din = m_sr[31:0]; nrx = 1; end
               end else begin
                  m_reg[a] = m_sr[31:0] & m_mask(a);
               end
            end else begin
               m_ra = a;
            end
         end
         if (core_wr && !m_tx) begin m_dout = core_wr_data; ntx = 1; end
         m_rx = nrx; m_tx = ntx;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tdo === m_sr[0], "R1 tdo", {31'b0, tdo}, {31'b0, m_sr[0]});
         chk(rx_full === m_rx, "R5 rx_full", {31'b0, rx_full}, {31'b0, m_rx});
         chk(tx_full === m_tx, "R7 tx_full", {31'b0, tx_full}, {31'b0, m_tx});
         chk(core_rd_data === m_din, "R5 core_rd_data", core_rd_data, m_din);
         chk(monitor_en === m_reg[0][4], "R9 monitor_en", {31'b0, monitor_en}, {31'b0, m_reg[0][4]});
         chk(vec_catch === m_reg[2][7:0], "R10 vec_catch", {24'b0, vec_catch}, {24'b0, m_reg[2][7:0]});
      end
   end

   task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d, output logic [37:0] got);
      logic [37:0] w;
      w = {wr, a, d};
      @(negedge clk); cap_en = 1'b1;
      @(negedge clk); cap_en = 1'b0;
      for (int i = 0; i < 38; i++) begin
         got[i] = tdo;
         shift_en = 1'b1; tdi = w[i];
         @(negedge clk);
      end
      shift_en = 1'b0; upd_en = 1'b1;
      @(negedge clk); upd_en = 1'b0;
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      logic [37:0] g;
      scan(1'b1, a, d, g);
   endtask

   // read with a trailing scan that points at channel control
   task automatic rd_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
      logic [37:0] g;
      scan(1'b0, a, 32'h0, g);
      scan(1'b0, 5'd4, 32'h0, g);
      chk(g[31:0] === exp, tag, g[31:0], exp);
      chk(g[37:32] === 6'b0, "R3 upper bits after capture", {26'b0, g[37:32]}, 32'h0);
   endtask

   task automatic core_write(input logic [31:0] d);
      @(negedge clk); core_wr = 1'b1; core_wr_data = d;
      @(negedge clk); core_wr = 1'b0;
   endtask

   task automatic core_read();
      @(negedge clk); core_rd = 1'b1;
      @(negedge clk); core_rd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      logic [37:0] g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_full === 1'b0 && tx_full === 1'b0, "R13 flags after reset", {30'b0, tx_full, rx_full}, 32'h0);
      chk(core_rd_data === 32'h0, "R13 channel word after reset", core_rd_data, 32'h0);
      // first capture uses reset read address 0
      scan(1'b0, 5'd0, 32'h0, g);
      chk(g[31:0] === 32'h0, "R13 reset read address 0", g[31:0], 32'h0);

      rd_reg(5'd4, 32'h6000_0000, "R4 channel control idle");
      wr_reg(5'd4, 32'hFFFF_FFFF);
      rd_reg(5'd4, 32'h6000_0000, "R4 control write ignored");

      wr_reg(5'd0, 32'hFFFF_FFFF);
      chk(monitor_en === 1'b1, "R9 monitor bit set", {31'b0, monitor_en}, 32'h1);
      rd_reg(5'd0, 32'h3F, "R2 R9 debug control masked");
      wr_reg(5'd0, 32'h2F);
      chk(monitor_en === 1'b0, "R9 halting mode", {31'b0, monitor_en}, 32'h0);
      stat_in = 10'h2A5;
      rd_reg(5'd1, 32'h2A5, "R9 debug status");

      wr_reg(5'd2, 32'h1234_56AB);
      rd_reg(5'd2, 32'hAB, "R10 vector catch");
      chk(vec_catch === 8'hAB, "R10 vec_catch pin", {24'b0, vec_catch}, 32'hAB);

      wr_reg(5'd9, 32'hDEAD_BEEF);
      wr_reg(5'd20, 32'hFFFF_FFFF);
      wr_reg(5'd21, 32'hFFFF_FFFF);
      wr_reg(5'd16, 32'h1234_5678);
      wr_reg(5'd13, 32'h0000_FFFF);
      rd_reg(5'd9, 32'hDEAD_BEEF, "R11 unit0 address mask");
      rd_reg(5'd20, 32'h1FF, "R11 unit1 control value 9 bits");
      rd_reg(5'd21, 32'hFF, "R11 unit1 control mask 8 bits");
      rd_reg(5'd16, 32'h1234_5678, "R11 unit1 address value");
      rd_reg(5'd13, 32'hFF, "R11 unit0 control mask");

      wr_reg(5'd3, 32'hFFFF_FFFF);
      wr_reg(5'd7, 32'hFFFF_FFFF);
      wr_reg(5'd14, 32'hFFFF_FFFF);
      wr_reg(5'd30, 32'hFFFF_FFFF);
      rd_reg(5'd3, 32'h0, "R12 address 3");
      rd_reg(5'd7, 32'h0, "R12 address 7");
      rd_reg(5'd14, 32'h0, "R12 address 14");
      rd_reg(5'd30, 32'h0, "R12 address 30");
      rd_reg(5'd9, 32'hDEAD_BEEF, "R12 no aliasing into watch");

      wr_reg(5'd5, 32'hCAFE_F00D);
      chk(rx_full === 1'b1, "R5 rx flag set", {31'b0, rx_full}, 32'h1);
      chk(core_rd_data === 32'hCAFE_F00D, "R5 word to core", core_rd_data, 32'hCAFE_F00D);
      rd_reg(5'd4, 32'h6000_0001, "R4 R flag visible");
      wr_reg(5'd5, 32'h1111_1111);
      chk(core_rd_data === 32'hCAFE_F00D, "R6 write while full dropped", core_rd_data, 32'hCAFE_F00D);
      core_read();
      chk(rx_full === 1'b0, "R5 core read clears flag", {31'b0, rx_full}, 32'h0);
      wr_reg(5'd5, 32'h2222_2222);
      chk(core_rd_data === 32'h2222_2222, "R5 second word accepted", core_rd_data, 32'h2222_2222);
      core_read();

      core_write(32'hA5A5_A5A5);
      chk(tx_full === 1'b1, "R7 tx flag set", {31'b0, tx_full}, 32'h1);
      core_write(32'h5A5A_5A5A);
      rd_reg(5'd4, 32'h6000_0002, "R4 W flag visible");
      rd_reg(5'd4, 32'h6000_0002, "R4 control capture no side effect");
      rd_reg(5'd5, 32'hA5A5_A5A5, "R8 dropped core write kept first word");
      chk(tx_full === 1'b0, "R7 consuming capture clears flag", {31'b0, tx_full}, 32'h0);

      // two consuming captures pop two words
      core_write(32'h0000_0077);
      scan(1'b0, 5'd5, 32'h0, g);
      scan(1'b0, 5'd5, 32'h0, g);
      chk(g[31:0] === 32'h77, "R7 first pop", g[31:0], 32'h77);
      core_write(32'h0000_0088);
      scan(1'b0, 5'd4, 32'h0, g);
      chk(g[31:0] === 32'h88, "R7 second pop", g[31:0], 32'h88);
      chk(tx_full === 1'b0, "R7 empty after second pop", {31'b0, tx_full}, 32'h0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule